// File: doc/BRIEF.md
# Cache Line-Fill Buffer Controller

This block holds one cache line between the external burst bus and the cache array. When a cacheable request misses the array, the controller asks for a burst and collects the beats into its line register. Once the last beat is in, it decides whether the line may be copied into the array. With the freeze control set, a line may go only into an array slot that is currently invalid. With freeze clear, the copy always happens. A line that freeze holds back stays in the buffer, and later requests to it are served from there.

The buffer can also work as a one-line instruction store for memory that is not cacheable. When the noncacheable-buffering control is set, a normal-type instruction fetch to a noncacheable address brings in a whole line by a burst. Repeat fetches to that line are then answered from the buffer with no bus traffic. Such a line is never copied into the array. It is lost on an invalidate-all or when the next fill starts. Other noncacheable accesses are flagged for a single direct bus access and do not touch the buffer.

Top module: `line_fill_buffer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the buffer holds no valid line, `req_ready` is 1, and `resp_valid`, `burst_req`, `req_bypass` and `arr_wr_en` are 0.
- R2: A request accepted as cacheable (`req_cacheable`=1) that misses both the buffer and the array (`req_arr_hit`=0) raises `burst_req` for exactly one cycle after acceptance, with `burst_addr` set to the line-aligned byte address. A cacheable request that hits the array starts no burst and gives no response.
- R3: A line is four 32-bit beats, and beat k fills word k. The line becomes valid only on the beat that carries `beat_last`. An accepted request whose line matches a valid buffer line sets `resp_valid` in the next cycle, with the word selected by word-address bits [1:0] of `req_waddr`.
- R4: With `freeze_en`=0, the cycle after the last beat of a cacheable fill raises `arr_wr_en` for one cycle. In that cycle `arr_wr_line` is the line address and `arr_wr_data` holds word k in bits [32k+31:32k].
- R5: With `freeze_en`=1 and `arr_tgt_valid`=1 in the write-back cycle, no array write happens. The line stays valid in the buffer and answers later hits.
- R6: With `freeze_en`=1 and `arr_tgt_valid`=0, the array write-back still happens.
- R7: With `ncbuf_en`=1, a noncacheable instruction fetch (`req_instr`=1) of transfer type 0 (`req_tt`=2'b00) starts a burst and is captured into the buffer. It is never written to the array, and `req_ready` returns to 1 right after its last beat.
- R8: A repeat fetch to a captured noncacheable line is answered from the buffer and starts no burst.
- R9: Any other noncacheable request that misses the buffer raises `req_bypass` for one cycle and starts no burst. This covers `ncbuf_en`=0, a nonzero type, and data accesses. The buffer contents stay unchanged.
- R10: `inv_all` clears the buffer line. While `inv_all` is high, `req_ready` is 0 and no response follows. A later request to the old line misses.
- R11: Starting any new fill discards the previous buffer line, including a captured noncacheable line.
- R12: While a fill or write-back is in progress, `req_ready` is 0 and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_waddr | input | WADDR_W (30) | Word address of the request |
| req_instr | input | 1 | Request is an instruction fetch |
| req_tt | input | 2 | Transfer type, 0 = normal |
| req_cacheable | input | 1 | Region is cacheable |
| req_arr_hit | input | 1 | Cache array hit for this request |
| req_ready | output | 1 | Request can be accepted this cycle |
| resp_valid | output | 1 | Buffer hit data valid |
| resp_data | output | DATA_W (32) | Buffer hit data |
| req_bypass | output | 1 | Request must go to the bus as a single access |
| ncbuf_en | input | 1 | Enable noncacheable instruction buffering |
| freeze_en | input | 1 | Freeze valid array lines |
| inv_all | input | 1 | Invalidate the buffer |
| burst_req | output | 1 | Start a line burst (one-cycle pulse) |
| burst_addr | output | ADDR_W (32) | Line-aligned burst byte address |
| beat_valid | input | 1 | Burst beat present |
| beat_data | input | DATA_W (32) | Burst beat data |
| beat_last | input | 1 | Final beat of the burst |
| arr_wr_en | output | 1 | Write the line into the cache array |
| arr_wr_line | output | TAG_W (28) | Line address for the array write |
| arr_wr_data | output | LINE_W (128) | Full line, word 0 in the low bits |
| arr_tgt_valid | input | 1 | Target array slot currently holds a valid line |

## Verification
The fill path is run four ways:
- freeze clear;
- freeze set over a valid slot;
- freeze set over an invalid slot;
- as a noncacheable capture.

These runs separate the write-back decision from the fill itself, and they show that a held-back line still serves hits. Noncacheable requests vary the buffering control, the transfer type and the buffer state. This shows whether capture, bypass and hit each need their own conditions. Invalidation is tried both as an explicit pulse and as a side effect of a new fill to another line. A request made while busy shows that requests are ignored mid-fill.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WB   = 2'd2
  } lfb_state_e;

  localparam logic [1:0] TT_NORMAL = 2'd0;

  // Capture a noncacheable access only for normal-type instruction reads
  function automatic logic nc_capture(input logic cacheable,
                                      input logic instr,
                                      input logic [1:0] tt,
                                      input logic enable);
    return enable && !cacheable && instr && (tt == TT_NORMAL);
  endfunction

endpackage

// File: rtl/lfb_tag_cmp.sv
module lfb_tag_cmp #(
  parameter int TAG_W = 28
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit
);

  always_comb begin
    hit = line_valid && (line_tag == req_tag);
  end

endmodule

// File: rtl/lfb_line_store.sv
module lfb_line_store #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int OFF_W  = $clog2(BEATS),
  localparam int LINE_W = DATA_W * BEATS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [LINE_W-1:0] line_out
);

  logic [DATA_W-1:0] word_q [BEATS];

  for (genvar w = 0; w < BEATS; w++) begin : g_word
    logic word_en;
    always_comb begin
      word_en = wr_en && (wr_idx == OFF_W'(w));
    end
    always_ff @(posedge clk) begin
      if (word_en) begin
        word_q[w] <= wr_data;
      end
    end
    assign line_out[w*DATA_W +: DATA_W] = word_q[w];
  end

  always_comb begin
    rd_data = word_q[rd_idx];
  end

endmodule

// File: rtl/lfb_fsm.sv
module lfb_fsm
  import lfb_pkg::*;
#(
  parameter int TAG_W = 28,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_instr,
  input  logic [1:0]       req_tt,
  input  logic             req_cacheable,
  input  logic             req_arr_hit,
  input  logic             buf_hit,
  input  logic             ncbuf_en,
  input  logic             freeze_en,
  input  logic             inv_all,
  input  logic             beat_valid,
  input  logic             beat_last,
  input  logic             arr_tgt_valid,
  output logic             req_ready,
  output logic             hit_accept,
  output logic             line_valid,
  output logic [TAG_W-1:0] line_tag,
  output logic             burst_req,
  output logic             req_bypass,
  output logic             beat_we,
  output logic [OFF_W-1:0] beat_idx,
  output logic             arr_wr_en
);

  lfb_state_e       st_q, st_n;
  logic             valid_q, valid_n;
  logic [TAG_W-1:0] tag_q, tag_n;
  logic             nc_q, nc_n;
  logic             kill_q, kill_n;
  logic [OFF_W-1:0] idx_q, idx_n;
  logic             burst_q, burst_n;
  logic             byp_q, byp_n;

  logic accept, capture, start_fill, bypass_go;

  // Request decode
  always_comb begin
    req_ready  = (st_q == ST_IDLE) && !inv_all;
    accept     = req_valid && req_ready;
    hit_accept = accept && buf_hit;
    capture    = nc_capture(req_cacheable, req_instr, req_tt, ncbuf_en);
    start_fill = accept && !buf_hit &&
                 ((req_cacheable && !req_arr_hit) || capture);
    bypass_go  = accept && !buf_hit && !req_cacheable && !capture;
    beat_we    = (st_q == ST_FILL) && beat_valid;
    arr_wr_en  = (st_q == ST_WB) && (!freeze_en || !arr_tgt_valid);
  end

  // Next state
  always_comb begin
    st_n    = st_q;
    valid_n = valid_q;
    tag_n   = tag_q;
    nc_n    = nc_q;
    kill_n  = kill_q;
    idx_n   = idx_q;
    burst_n = start_fill;
    byp_n   = bypass_go;
    case (st_q)
      ST_IDLE: begin
        if (start_fill) begin
          st_n    = ST_FILL;
          valid_n = 1'b0;
          tag_n   = req_tag;
          nc_n    = capture;
          kill_n  = 1'b0;
          idx_n   = '0;
        end
      end
      ST_FILL: begin
        if (inv_all) begin
          kill_n = 1'b1;
        end
        if (beat_we) begin
          idx_n = idx_q + OFF_W'(1);
          if (beat_last) begin
            valid_n = !(kill_q || inv_all);
            st_n    = (nc_q || kill_q || inv_all) ? ST_IDLE : ST_WB;
          end
        end
      end
      ST_WB: begin
        st_n = ST_IDLE;
      end
      default: begin
        st_n = ST_IDLE;
      end
    endcase
    if (inv_all) begin
      valid_n = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      valid_q <= 1'b0;
      tag_q   <= '0;
      nc_q    <= 1'b0;
      kill_q  <= 1'b0;
      idx_q   <= '0;
      burst_q <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      valid_q <= valid_n;
      tag_q   <= tag_n;
      nc_q    <= nc_n;
      kill_q  <= kill_n;
      idx_q   <= idx_n;
      burst_q <= burst_n;
      byp_q   <= byp_n;
    end
  end

  assign line_valid = valid_q;
  assign line_tag   = tag_q;
  assign burst_req  = burst_q;
  assign req_bypass = byp_q;
  assign beat_idx   = idx_q;

endmodule

// File: rtl/line_fill_buffer.sv
module line_fill_buffer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int BYTE_W  = $clog2(DATA_W / 8),
  localparam int OFF_W   = $clog2(BEATS),
  localparam int WADDR_W = ADDR_W - BYTE_W,
  localparam int TAG_W   = WADDR_W - OFF_W,
  localparam int LINE_W  = DATA_W * BEATS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [WADDR_W-1:0] req_waddr,
  input  logic               req_instr,
  input  logic [1:0]         req_tt,
  input  logic               req_cacheable,
  input  logic               req_arr_hit,
  output logic               req_ready,
  output logic               resp_valid,
  output logic [DATA_W-1:0]  resp_data,
  output logic               req_bypass,
  input  logic               ncbuf_en,
  input  logic               freeze_en,
  input  logic               inv_all,
  output logic               burst_req,
  output logic [ADDR_W-1:0]  burst_addr,
  input  logic               beat_valid,
  input  logic [DATA_W-1:0]  beat_data,
  input  logic               beat_last,
  output logic               arr_wr_en,
  output logic [TAG_W-1:0]   arr_wr_line,
  output logic [LINE_W-1:0]  arr_wr_data,
  input  logic               arr_tgt_valid
);

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              buf_hit;
  logic              hit_accept;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic              beat_we;
  logic [OFF_W-1:0]  beat_idx;
  logic [DATA_W-1:0] rd_data;

  logic              resp_valid_q, resp_valid_n;
  logic [DATA_W-1:0] resp_data_q, resp_data_n;

  assign req_tag = req_waddr[WADDR_W-1:OFF_W];
  assign req_off = req_waddr[OFF_W-1:0];

  lfb_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .req_tag    (req_tag),
    .hit        (buf_hit)
  );

  lfb_fsm #(.TAG_W(TAG_W), .OFF_W(OFF_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_tag       (req_tag),
    .req_instr     (req_instr),
    .req_tt        (req_tt),
    .req_cacheable (req_cacheable),
    .req_arr_hit   (req_arr_hit),
    .buf_hit       (buf_hit),
    .ncbuf_en      (ncbuf_en),
    .freeze_en     (freeze_en),
    .inv_all       (inv_all),
    .beat_valid    (beat_valid),
    .beat_last     (beat_last),
    .arr_tgt_valid (arr_tgt_valid),
    .req_ready     (req_ready),
    .hit_accept    (hit_accept),
    .line_valid    (line_valid),
    .line_tag      (line_tag),
    .burst_req     (burst_req),
    .req_bypass    (req_bypass),
    .beat_we       (beat_we),
    .beat_idx      (beat_idx),
    .arr_wr_en     (arr_wr_en)
  );

  lfb_line_store #(.DATA_W(DATA_W), .BEATS(BEATS)) u_store (
    .clk      (clk),
    .wr_en    (beat_we),
    .wr_idx   (beat_idx),
    .wr_data  (beat_data),
    .rd_idx   (req_off),
    .rd_data  (rd_data),
    .line_out (arr_wr_data)
  );

  // Response register, loaded on an accepted buffer hit
  always_comb begin
    resp_valid_n = hit_accept;
    resp_data_n  = hit_accept ? rd_data : resp_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= resp_valid_n;
      resp_data_q  <= resp_data_n;
    end
  end

  assign resp_valid  = resp_valid_q;
  assign resp_data   = resp_data_q;
  assign burst_addr  = {line_tag, {(ADDR_W - TAG_W){1'b0}}};
  assign arr_wr_line = line_tag;

endmodule

// File: rtl/line_fill_buffer_chk.sv
module line_fill_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic inv_all,
  input logic freeze_en,
  input logic arr_tgt_valid,
  input logic arr_wr_en,
  input logic burst_req,
  input logic req_bypass,
  input logic resp_valid
);

  p_burst_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |=> !burst_req);

  p_resp_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));

  p_write_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |=> !arr_wr_en);

  p_frozen_valid_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> !(freeze_en && arr_tgt_valid));

  p_bypass_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_bypass |-> (!burst_req && !resp_valid));

  p_inv_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !resp_valid);

  p_busy_after_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> !req_ready);

endmodule

bind line_fill_buffer line_fill_buffer_chk u_chk (.*);

// File: tb/line_fill_buffer_tb_top.sv
module line_fill_buffer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WADDR_W = 30;
  localparam int TAG_W   = 28;

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic [WADDR_W-1:0] req_waddr;
  logic               req_instr;
  logic [1:0]         req_tt;
  logic               req_cacheable;
  logic               req_arr_hit;
  logic               req_ready;
  logic               resp_valid;
  logic [31:0]        resp_data;
  logic               req_bypass;
  logic               ncbuf_en;
  logic               freeze_en;
  logic               inv_all;
  logic               burst_req;
  logic [31:0]        burst_addr;
  logic               beat_valid;
  logic [31:0]        beat_data;
  logic               beat_last;
  logic               arr_wr_en;
  logic [TAG_W-1:0]   arr_wr_line;
  logic [127:0]       arr_wr_data;
  logic               arr_tgt_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [31:0] exp_q[$];
  string       exp_tag_q[$];

  line_fill_buffer dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] bw(input logic [31:0] base, input int i);
    return base ^ (32'hA5C3_0000 | 32'(i + 1));
  endfunction

  function automatic logic [127:0] bline(input logic [31:0] base);
    return {bw(base, 3), bw(base, 2), bw(base, 1), bw(base, 0)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Scoreboard monitor for buffer responses
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected response", 128'(resp_data), 0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag_q.pop_front();
        chk(resp_data == e, t, 128'(resp_data), 128'(e));
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic c, input logic ins,
                       input logic [1:0] tt, input logic ah);
    req_valid = 1'b1; req_waddr = a[31:2]; req_cacheable = c;
    req_instr = ins; req_tt = tt; req_arr_hit = ah;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic c, input logic ins,
                            input logic [31:0] base, input string rq);
    exp_q.push_back(bw(base, int'(a[3:2])));
    exp_tag_q.push_back(rq);
    issue(a, c, ins, 2'd0, 1'b0);
    chk(burst_req == 1'b0, {rq, " no burst on hit"}, 128'(burst_req), 0);
  endtask

  task automatic fill_line(input logic [31:0] base, input bit exp_wr, input string rq);
    for (int i = 0; i < 4; i++) begin
      beat_valid = 1'b1; beat_data = bw(base, i); beat_last = (i == 3);
      @(negedge clk);
    end
    beat_valid = 1'b0; beat_last = 1'b0;
    chk(arr_wr_en == exp_wr, {rq, " write-back decision"}, 128'(arr_wr_en), 128'(exp_wr));
    if (exp_wr) begin
      chk(arr_wr_data == bline(base), {rq, " line data"}, arr_wr_data, bline(base));
      chk(arr_wr_line == base[31:4], {rq, " line address"}, 128'(arr_wr_line),
          128'(base[31:4]));
    end
    @(negedge clk);
  endtask

  task automatic expect_burst(input logic [31:0] base, input string rq);
    chk(burst_req == 1'b1, {rq, " burst started"}, 128'(burst_req), 1);
    chk(burst_addr == base, {rq, " burst address"}, 128'(burst_addr), 128'(base));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_waddr = '0; req_instr = 0; req_tt = 0;
    req_cacheable = 0; req_arr_hit = 0; ncbuf_en = 0; freeze_en = 0; inv_all = 0;
    beat_valid = 0; beat_data = '0; beat_last = 0; arr_tgt_valid = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !burst_req && !req_bypass && !arr_wr_en,
        "R1 reset outputs", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !burst_req && !arr_wr_en, "R1 after release", 0, 0);

    // R2: cacheable array hit does nothing
    issue(32'h0800_0000, 1, 0, 2'd0, 1);
    chk(!burst_req && !req_bypass, "R2 array hit no burst", 128'(burst_req), 0);

    // R2/R4: cacheable miss, freeze off
    issue(32'h1000_0044, 1, 0, 2'd0, 0);
    expect_burst(32'h1000_0040, "R2");
    // R12: request while busy is ignored
    chk(req_ready == 1'b0, "R12 busy not ready", 128'(req_ready), 0);
    issue(32'h1100_0000, 1, 0, 2'd0, 0);
    chk(burst_req == 1'b0, "R12 busy request ignored", 128'(burst_req), 0);
    fill_line(32'h1000_0040, 1, "R4");
    expect_hit(32'h1000_0048, 1, 0, 32'h1000_0040, "R3 hit word2");
    expect_hit(32'h1000_0040, 1, 0, 32'h1000_0040, "R3 hit word0");

    // R5: freeze over valid target
    freeze_en = 1; arr_tgt_valid = 1;
    issue(32'h2000_0010, 1, 0, 2'd0, 0);
    expect_burst(32'h2000_0010, "R5");
    fill_line(32'h2000_0010, 0, "R5");
    expect_hit(32'h2000_001C, 1, 0, 32'h2000_0010, "R5 held line hit");

    // R6: freeze over invalid target
    arr_tgt_valid = 0;
    issue(32'h3000_0000, 1, 0, 2'd0, 0);
    expect_burst(32'h3000_0000, "R6");
    fill_line(32'h3000_0000, 1, "R6");
    freeze_en = 0;

    // R7/R8: noncacheable instruction capture
    ncbuf_en = 1;
    issue(32'h4000_0020, 0, 1, 2'd0, 0);
    expect_burst(32'h4000_0020, "R7");
    for (int i = 0; i < 4; i++) begin
      beat_valid = 1'b1; beat_data = bw(32'h4000_0020, i); beat_last = (i == 3);
      @(negedge clk);
    end
    beat_valid = 0; beat_last = 0;
    chk(arr_wr_en == 1'b0, "R7 no array write", 128'(arr_wr_en), 0);
    chk(req_ready == 1'b1, "R7 ready after capture", 128'(req_ready), 1);
    expect_hit(32'h4000_0024, 0, 1, 32'h4000_0020, "R8 repeat fetch");

    // R9: bypass cases
    issue(32'h6000_0000, 0, 1, 2'd1, 0);
    chk(req_bypass && !burst_req, "R9 nonzero type bypass", 128'(req_bypass), 1);
    ncbuf_en = 0;
    issue(32'h5000_0000, 0, 1, 2'd0, 0);
    chk(req_bypass && !burst_req, "R9 buffering off bypass", 128'(req_bypass), 1);
    issue(32'h5000_0000, 0, 0, 2'd0, 0);
    chk(req_bypass && !burst_req, "R9 data access bypass", 128'(req_bypass), 1);
    expect_hit(32'h4000_0028, 0, 1, 32'h4000_0020, "R9 buffer unchanged");
    ncbuf_en = 1;

    // R11: new fill discards the captured line
    issue(32'h7000_0000, 1, 0, 2'd0, 0);
    expect_burst(32'h7000_0000, "R11");
    fill_line(32'h7000_0000, 1, "R11");
    issue(32'h4000_0020, 0, 1, 2'd0, 0);
    chk(burst_req && !resp_valid, "R11 old nc line misses", 128'(burst_req), 1);
    fill_line(32'h4000_0020, 0, "R11 refill");

    // R10: invalidate-all
    inv_all = 1;
    req_valid = 1; req_waddr = 30'h1000_0008; req_cacheable = 0; req_instr = 1;
    req_tt = 0; req_arr_hit = 0;
    #1;
    chk(req_ready == 1'b0, "R10 not ready during invalidate", 128'(req_ready), 0);
    @(negedge clk);
    req_valid = 0; inv_all = 0;
    chk(resp_valid == 1'b0 && burst_req == 1'b0, "R10 no response", 128'(resp_valid), 0);
    issue(32'h4000_0020, 0, 1, 2'd0, 0);
    expect_burst(32'h4000_0020, "R10 miss after invalidate");
    fill_line(32'h4000_0020, 0, "R10 refill");
    expect_hit(32'h4000_002C, 0, 1, 32'h4000_0020, "R3 hit word3");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all responses seen", 128'(exp_q.size()), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule